// File: doc/BRIEF.md
# Shift and Rotate Unit with Condition Flags

This block takes one operand of byte, word or long size and moves its bits left or right by a count from 0 to 63. It offers eight operations. Arithmetic and logical shifts go in either direction. Plain rotates go in either direction. Rotates through the extend flag also go in either direction, and they treat the operand and the incoming X bit as one ring that is one bit wider than the operand. Alongside the result it produces the five condition flags X, N, Z, V and C. It also produces an update mask that says which of those flags the consumer should commit.

The datapath is combinational. Its outputs are captured in one register stage, so every output reflects the inputs sampled at the previous rising clock edge. Bits above the selected operand size never reach the result. The consumer uses the update mask to decide whether X is written back. The N, Z, V and C flags are always written back.

Top module: `shf_unit`

## Requirements
- R1: All outputs are registered. They show the operation applied to the inputs sampled at the previous rising edge. A rising edge with `rst_n` low clears `result_o`, `flags_o` and `upd_o` to zero.
- R2: The operation code is `op_i` (0 arithmetic left, 1 logical left, 2 arithmetic right, 3 logical right, 4 rotate left, 5 rotate right, 6 rotate left through X, 7 rotate right through X). For codes 0, 1 and 3, vacated positions fill with zeros, and a count at or above the operand width gives a zero result.
- R3: Arithmetic right shift (code 2) fills vacated positions with copies of the operand's sign bit. A count at or above the width gives all bits equal to the sign.
- R4: Plain rotates (codes 4 and 5) move the operand circularly by the count modulo the operand width.
- R5: Rotates through X (codes 6 and 7) move the (width+1)-bit ring {X, operand} circularly by the count modulo width+1. The bit that lands in the X position becomes the new X and C.
- R6: For a shift with a nonzero count r and operand width w, C is the last bit shifted out. For left shifts that is operand bit w−r. For right shifts that is operand bit r−1. When that bit lies beyond the operand, C is 0 for codes 0, 1 and 3 and the sign bit for code 2.
- R7: For a plain rotate with a nonzero count, C equals the result LSB (left) or the result MSB (right). For a rotate through X with a nonzero count, C equals the new X.
- R8: For arithmetic left shift, V is set when the sign position takes a different value at any step of the shift. With count r < w, that means operand bits w−1 down to w−1−r are not all equal. With r ≥ w, it means the operand is nonzero. With r = 0, V is 0.
- R9: V is 0 for every operation other than arithmetic left shift.
- R10: With a zero count, the result equals the size-truncated operand and X is not loaded. C is 0 for shifts and plain rotates, and C equals the incoming X for rotates through X.
- R11: `flags_o` and `upd_o` both use bit order [4]=X, [3]=N, [2]=Z, [1]=V, [0]=C. The update mask bits for N, Z, V and C are always 1. The X mask bit is 1, with X equal to C, for shifts and rotates through X with a nonzero count. Otherwise the X mask bit is 0 and the X output equals `x_i`. Plain rotates never load X.
- R12: N equals the result bit at the MSB of the selected size. Z is 1 exactly when every result bit is zero.
- R13: `size_i` selects 0 byte (low quarter of the data path), 1 word (low half), 2 or 3 long (full width). Input bits above the size are ignored, and result bits above it are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 3 | Operation code |
| size_i | input | 2 | Operand size select |
| cnt_i | input | CNT_W | Shift or rotate count |
| data_i | input | DATA_W | Operand |
| x_i | input | 1 | Current extend flag |
| result_o | output | DATA_W | Registered result |
| flags_o | output | 5 | New flags {X,N,Z,V,C} |
| upd_o | output | 5 | Flag update mask {X,N,Z,V,C} |

## Verification
The hardest case to reach is the left arithmetic overflow that happens partway through the shift. In that case the sign position changes and may later return, so the final MSB gives no hint of it. Random operands almost never line up the top bits and count like that. The stimulus therefore sweeps patterns with only the top one or two bits set, and with all bits set, against counts of 1, 2, w−1, w and w+1 for every size. Rotates through X are swept over counts that wrap past width+1, in both X states, so that the ring modulo and the X-to-C handoff are exercised at their edges.

// File: rtl/shf_pkg.sv
// Shared types for the shift and rotate unit.
// Assumes op codes and flag bit order are fixed by the consumers of the block.
package shf_pkg;

    typedef enum logic [2:0] {
        OP_ASL = 3'd0,
        OP_LSL = 3'd1,
        OP_ASR = 3'd2,
        OP_LSR = 3'd3,
        OP_ROL = 3'd4,
        OP_ROR = 3'd5,
        OP_RXL = 3'd6,
        OP_RXR = 3'd7
    } shf_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_LONG  = 2'd2,
        SZ_LONG2 = 2'd3
    } shf_size_e;

    localparam int FLG_W = 5;
    localparam int FLG_X = 4;
    localparam int FLG_N = 3;
    localparam int FLG_Z = 2;
    localparam int FLG_V = 1;
    localparam int FLG_C = 0;

endpackage

// File: rtl/shf_size_dec.sv
// Operand size decoder: turns the size code into width, MSB index and a bit mask.
// Assumes DATA_W is a multiple of 4; byte is a quarter, word half the data path.
module shf_size_dec #(
    parameter int DATA_W = 32,
    parameter int WID_W  = $clog2(DATA_W + 1),
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  shf_pkg::shf_size_e  size,
    output logic [WID_W-1:0]    width,
    output logic [IDX_W-1:0]    msb,
    output logic [DATA_W-1:0]   mask
);
    import shf_pkg::*;

    localparam int W_BYTE = DATA_W / 4;
    localparam int W_WORD = DATA_W / 2;

    // Select width and MSB index for the size code
    always_comb begin : p_decode
        unique case (size)
            SZ_BYTE: begin
                width = WID_W'(W_BYTE);
                msb   = IDX_W'(W_BYTE - 1);
            end
            SZ_WORD: begin
                width = WID_W'(W_WORD);
                msb   = IDX_W'(W_WORD - 1);
            end
            default: begin
                width = WID_W'(DATA_W);
                msb   = IDX_W'(DATA_W - 1);
            end
        endcase
    end

    // Mask of the bits that belong to the operand
    always_comb begin : p_mask
        mask = {DATA_W{1'b1}} >> (DATA_W - int'(width));
    end

endmodule

// File: rtl/shf_core.sv
// Shift/rotate datapath: builds every candidate result, the shifted-out bit
// and the overflow term, then selects by operation.
// Assumes width is one of DATA_W/4, DATA_W/2, DATA_W and msb equals width-1.
module shf_core #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 6,
    parameter int WID_W  = $clog2(DATA_W + 1),
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  shf_pkg::shf_op_e    op,
    input  logic [CNT_W-1:0]    cnt,
    input  logic [WID_W-1:0]    width,
    input  logic [IDX_W-1:0]    msb,
    input  logic [DATA_W-1:0]   mask,
    input  logic [DATA_W-1:0]   data,
    input  logic                x_in,
    output logic [DATA_W-1:0]   res,
    output logic                c_out,
    output logic                v_out,
    output logic                load_x
);
    import shf_pkg::*;

    int                 w_i;
    int                 r_i;
    int                 rot_i;
    int                 rox_i;
    logic               sign;
    logic               nz;
    logic [DATA_W-1:0]  d_m;
    logic [DATA_W-1:0]  sx;
    logic [DATA_W-1:0]  lsl_v;
    logic [DATA_W-1:0]  lsr_v;
    logic [DATA_W-1:0]  asr_full;
    logic [DATA_W-1:0]  asr_v;
    logic [DATA_W-1:0]  rol_v;
    logic [DATA_W-1:0]  ror_v;
    logic [DATA_W:0]    ring;
    logic [DATA_W:0]    ring_mask;
    logic [DATA_W:0]    rxl_full;
    logic [DATA_W:0]    rxr_full;
    logic               c_lft;
    logic               c_lsr;
    logic               c_asr;
    logic               v_asl;

    // Candidate results for all eight operations
    always_comb begin : p_datapath
        w_i       = int'(width);
        r_i       = int'(cnt);
        rot_i     = r_i % w_i;
        rox_i     = r_i % (w_i + 1);
        nz        = (cnt != '0);
        d_m       = data & mask;
        sign      = d_m[msb];
        sx        = d_m | (sign ? ~mask : '0);
        lsl_v     = (d_m << cnt) & mask;
        lsr_v     = d_m >> cnt;
        asr_full  = $signed(sx) >>> cnt;
        asr_v     = asr_full & mask;
        rol_v     = ((d_m << rot_i) | (d_m >> (w_i - rot_i))) & mask;
        ror_v     = ((d_m >> rot_i) | (d_m << (w_i - rot_i))) & mask;
        ring        = {1'b0, d_m};
        ring[width] = x_in;
        ring_mask = {(DATA_W + 1){1'b1}} >> (DATA_W - w_i);
        rxl_full  = ((ring << rox_i) | (ring >> (w_i + 1 - rox_i))) & ring_mask;
        rxr_full  = ((ring >> rox_i) | (ring << (w_i + 1 - rox_i))) & ring_mask;
    end

    // Last bit shifted out on each side, and sign-change detection for left arithmetic
    always_comb begin : p_edge_bits
        c_lft = 1'b0;
        c_lsr = 1'b0;
        c_asr = sign;
        v_asl = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i == w_i - r_i) begin
                c_lft = d_m[i];
            end
            if (i == r_i - 1 && i < w_i) begin
                c_lsr = d_m[i];
                c_asr = d_m[i];
            end
            if (i < w_i && i + r_i >= w_i - 1 && d_m[i] != sign) begin
                v_asl = 1'b1;
            end
        end
        if (r_i >= w_i) begin
            v_asl = |d_m;
        end
    end

    // Pick the result and flag terms for the requested operation
    always_comb begin : p_select
        res    = d_m;
        c_out  = 1'b0;
        v_out  = 1'b0;
        load_x = nz;
        unique case (op)
            OP_ASL: begin
                res   = lsl_v;
                c_out = nz & c_lft;
                v_out = nz & v_asl;
            end
            OP_LSL: begin
                res   = lsl_v;
                c_out = nz & c_lft;
            end
            OP_ASR: begin
                res   = asr_v;
                c_out = nz & c_asr;
            end
            OP_LSR: begin
                res   = lsr_v;
                c_out = nz & c_lsr;
            end
            OP_ROL: begin
                res    = rol_v;
                c_out  = nz & rol_v[0];
                load_x = 1'b0;
            end
            OP_ROR: begin
                res    = ror_v;
                c_out  = nz & ror_v[msb];
                load_x = 1'b0;
            end
            OP_RXL: begin
                res   = rxl_full[DATA_W-1:0] & mask;
                c_out = rxl_full[width];
            end
            default: begin
                res   = rxr_full[DATA_W-1:0] & mask;
                c_out = rxr_full[width];
            end
        endcase
    end

endmodule

// File: rtl/shf_flags.sv
// Flag assembly: derives N and Z from the result, merges X, and builds the update mask.
// Assumes res is already truncated to the operand size.
module shf_flags #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0]           res,
    input  logic [IDX_W-1:0]            msb,
    input  logic                        c_in,
    input  logic                        v_in,
    input  logic                        load_x,
    input  logic                        x_in,
    output logic [shf_pkg::FLG_W-1:0]   flags,
    output logic [shf_pkg::FLG_W-1:0]   upd
);
    import shf_pkg::*;

    // Place each flag at its bit position
    always_comb begin : p_assemble
        flags        = '0;
        flags[FLG_X] = load_x ? c_in : x_in;
        flags[FLG_N] = res[msb];
        flags[FLG_Z] = (res == '0);
        flags[FLG_V] = v_in;
        flags[FLG_C] = c_in;
        upd          = '1;
        upd[FLG_X]   = load_x;
    end

endmodule

// File: rtl/shf_unit.sv
// Top of the shift and rotate unit: size decode, datapath, flag assembly and
// one output register stage with synchronous active-low reset.
// Assumes inputs are stable around the rising edge of clk.
module shf_unit #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          op_i,
    input  logic [1:0]          size_i,
    input  logic [CNT_W-1:0]    cnt_i,
    input  logic [DATA_W-1:0]   data_i,
    input  logic                x_i,
    output logic [DATA_W-1:0]   result_o,
    output logic [4:0]          flags_o,
    output logic [4:0]          upd_o
);
    import shf_pkg::*;

    localparam int WID_W = $clog2(DATA_W + 1);
    localparam int IDX_W = $clog2(DATA_W);

    logic [WID_W-1:0]   width;
    logic [IDX_W-1:0]   msb;
    logic [DATA_W-1:0]  mask;
    logic [DATA_W-1:0]  res_c;
    logic               c_c;
    logic               v_c;
    logic               load_x;
    logic [FLG_W-1:0]   flags_c;
    logic [FLG_W-1:0]   upd_c;

    shf_size_dec #(
        .DATA_W (DATA_W),
        .WID_W  (WID_W),
        .IDX_W  (IDX_W)
    ) u_size_dec (
        .size   (shf_size_e'(size_i)),
        .width  (width),
        .msb    (msb),
        .mask   (mask)
    );

    shf_core #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .WID_W  (WID_W),
        .IDX_W  (IDX_W)
    ) u_core (
        .op     (shf_op_e'(op_i)),
        .cnt    (cnt_i),
        .width  (width),
        .msb    (msb),
        .mask   (mask),
        .data   (data_i),
        .x_in   (x_i),
        .res    (res_c),
        .c_out  (c_c),
        .v_out  (v_c),
        .load_x (load_x)
    );

    shf_flags #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_flags (
        .res    (res_c),
        .msb    (msb),
        .c_in   (c_c),
        .v_in   (v_c),
        .load_x (load_x),
        .x_in   (x_i),
        .flags  (flags_c),
        .upd    (upd_c)
    );

    // Capture result, flags and mask; clear them in reset
    always_ff @(posedge clk) begin : p_out_reg
        if (!rst_n) begin
            result_o <= '0;
            flags_o  <= '0;
            upd_o    <= '0;
        end else begin
            result_o <= res_c;
            flags_o  <= flags_c;
            upd_o    <= upd_c;
        end
    end

endmodule

// File: rtl/shf_unit_chk.sv
// Property checker for shf_unit, attached by bind. Relates registered outputs
// to the inputs sampled one edge earlier.
module shf_unit_chk #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          op_i,
    input  logic [1:0]          size_i,
    input  logic [CNT_W-1:0]    cnt_i,
    input  logic                x_i,
    input  logic [DATA_W-1:0]   result_o,
    input  logic [4:0]          flags_o,
    input  logic [4:0]          upd_o
);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (result_o == '0 && flags_o == '0 && upd_o == '0));

    p_byte_upper_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (size_i == 2'd0) |=> (result_o[DATA_W-1:DATA_W/4] == '0));

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != 3'd0) |=> !flags_o[1]);

    p_rotate_keeps_x_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd4 || op_i == 3'd5) |=> (!upd_o[4] && flags_o[4] == $past(x_i)));

    p_zero_cnt_clear_c_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_i == '0 && op_i < 3'd6) |=> (!flags_o[0] && !upd_o[4]));

    p_zero_cnt_rox_c_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_i == '0 && op_i >= 3'd6) |=> (flags_o[0] == $past(x_i) && !upd_o[4]));

    p_x_follows_c_r11: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o[4] |-> (flags_o[4] == flags_o[0]));

    p_zero_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (flags_o[2] == (result_o == '0)));

endmodule

bind shf_unit shf_unit_chk #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op_i),
    .size_i   (size_i),
    .cnt_i    (cnt_i),
    .x_i      (x_i),
    .result_o (result_o),
    .flags_o  (flags_o),
    .upd_o    (upd_o)
);

// File: tb/shf_unit_bench.sv
`timescale 1ns/1ps
// Bench for shf_unit: a bit-at-a-time reference model predicts each cycle's
// outputs, predictions are queued and compared one clock later.
module shf_unit_bench;

    localparam int DATA_W = 32;
    localparam int CNT_W  = 6;

    typedef struct {
        logic [DATA_W-1:0] res;
        logic [DATA_W-1:0] mask;
        logic [4:0]        flg;
        logic [4:0]        upd;
        int                op;
        int                cnt;
    } exp_t;

    logic               clk = 1'b0;
    logic               rst_n;
    logic [2:0]         op_i;
    logic [1:0]         size_i;
    logic [CNT_W-1:0]   cnt_i;
    logic [DATA_W-1:0]  data_i;
    logic               x_i;
    logic [DATA_W-1:0]  result_o;
    logic [4:0]         flags_o;
    logic [4:0]         upd_o;

    int   n_checks = 0;
    int   n_fail   = 0;
    exp_t q[$];

    shf_unit #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shf_unit (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .size_i(size_i), .cnt_i(cnt_i),
        .data_i(data_i), .x_i(x_i), .result_o(result_o), .flags_o(flags_o), .upd_o(upd_o)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Reference: moves the operand one position per step
    task automatic model(input int op, input int size, input int cnt,
                         input logic [DATA_W-1:0] data, input logic x, output exp_t e);
        int w;
        logic [DATA_W-1:0] mask, val;
        logic c, v, xx, outb, msb0, ldx, xo;
        w = (size == 0) ? DATA_W / 4 : (size == 1) ? DATA_W / 2 : DATA_W;
        mask = '0;
        for (int i = 0; i < w; i++) mask[i] = 1'b1;
        val = data & mask;
        c = 1'b0; v = 1'b0; xx = x; outb = 1'b0;
        for (int k = 0; k < cnt; k++) begin
            msb0 = val[w-1];
            case (op)
                0, 1: begin
                    outb = val[w-1];
                    val = (val << 1) & mask;
                    if (op == 0 && val[w-1] != msb0) v = 1'b1;
                end
                2: begin outb = val[0]; val = (val >> 1) | (DATA_W'(msb0) << (w-1)); end
                3: begin outb = val[0]; val = val >> 1; end
                4: begin outb = val[w-1]; val = ((val << 1) | DATA_W'(outb)) & mask; end
                5: begin outb = val[0]; val = (val >> 1) | (DATA_W'(outb) << (w-1)); end
                6: begin outb = val[w-1]; val = ((val << 1) | DATA_W'(xx)) & mask; xx = outb; end
                default: begin outb = val[0]; val = (val >> 1) | (DATA_W'(xx) << (w-1)); xx = outb; end
            endcase
            c = outb;
        end
        if (op >= 6) c = xx;
        ldx = (op < 4 || op >= 6) && cnt != 0;
        xo  = ldx ? c : x;
        e.res  = val;
        e.mask = mask;
        e.flg  = {xo, val[w-1], (val == '0), v, c};
        e.upd  = {ldx, 4'b1111};
        e.op   = op;
        e.cnt  = cnt;
    endtask

    task automatic compare(input exp_t e);
        string rt, ct;
        if (e.cnt == 0)   rt = "R10";
        else if (e.op == 2) rt = "R3";
        else if (e.op < 4)  rt = "R2";
        else if (e.op < 6)  rt = "R4";
        else                rt = "R5";
        ct = (e.cnt == 0) ? "R10" : (e.op < 4) ? "R6" : "R7";
        chk(result_o == e.res, rt, "result", result_o, e.res);
        chk((result_o & ~e.mask) == '0, "R13", "bits above size", result_o & ~e.mask, '0);
        chk(flags_o[0] == e.flg[0], ct, "C flag", DATA_W'(flags_o[0]), DATA_W'(e.flg[0]));
        chk(flags_o[1] == e.flg[1], (e.op == 0) ? "R8" : "R9", "V flag",
            DATA_W'(flags_o[1]), DATA_W'(e.flg[1]));
        chk(flags_o[3:2] == e.flg[3:2], "R12", "N,Z flags", DATA_W'(flags_o[3:2]), DATA_W'(e.flg[3:2]));
        chk(flags_o[4] == e.flg[4] && upd_o == e.upd, "R11", "X flag and update mask",
            DATA_W'({flags_o[4], upd_o}), DATA_W'({e.flg[4], e.upd}));
    endtask

    // One cycle: check the previous prediction, then apply new inputs
    task automatic step(input int op, input int size, input int cnt,
                        input logic [DATA_W-1:0] data, input logic x);
        exp_t e;
        @(negedge clk);
        if (q.size() > 0) compare(q.pop_front());
        op_i = 3'(op); size_i = 2'(size); cnt_i = CNT_W'(cnt); data_i = data; x_i = x;
        model(op, size, cnt, data, x, e);
        q.push_back(e);
    endtask

    task automatic reset_and_check();
        @(negedge clk);
        if (q.size() > 0) compare(q.pop_front());
        rst_n = 1'b0;
        q.delete();
        @(negedge clk);
        chk(result_o == '0 && flags_o == '0 && upd_o == '0, "R1", "outputs after reset",
            DATA_W'({result_o != '0, flags_o, upd_o}), '0);
        rst_n = 1'b1;
    endtask

    function automatic logic [DATA_W-1:0] pat(input int p, input int size);
        int w;
        w = (size == 0) ? DATA_W / 4 : (size == 1) ? DATA_W / 2 : DATA_W;
        case (p)
            0: return '0;
            1: return '1;
            2: return DATA_W'(1) << (w - 1);
            3: return DATA_W'(3) << (w - 2);
            default: return DATA_W'($urandom);
        endcase
    endfunction

    initial begin : p_watchdog
        #(8ns * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : p_main
        int cl[13] = '{0, 1, 2, 7, 8, 9, 15, 16, 17, 31, 32, 33, 63};
        rst_n = 1'b0; op_i = '0; size_i = '0; cnt_i = '0; data_i = '0; x_i = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(result_o == '0 && flags_o == '0 && upd_o == '0, "R1", "reset state",
            DATA_W'({result_o != '0, flags_o, upd_o}), '0);
        rst_n = 1'b1;
        // Directed sweep over operation, size, boundary counts, patterns and X
        for (int op = 0; op < 8; op++)
            for (int sz = 0; sz < 3; sz++)
                for (int ci = 0; ci < 13; ci++)
                    for (int p = 0; p < 5; p++)
                        for (int xb = 0; xb < 2; xb++)
                            step(op, sz, cl[ci], pat(p, sz), xb[0]);
        reset_and_check();
        // Random mix including size code 3
        for (int n = 0; n < 3000; n++)
            step(int'($urandom % 8), int'($urandom % 4), int'($urandom % 64),
                 DATA_W'($urandom), 1'($urandom));
        @(negedge clk);
        if (q.size() > 0) compare(q.pop_front());
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule